// File: doc/BRIEF.md
# Six-Pin Shared GPIO Port with SPI and Serial Pin Override

This block is a six-pin bidirectional general-purpose port whose pins are also claimed by an SPI engine and by an asynchronous serial receiver/transmitter. Software sees two registers through a one-cycle write port with combinational readback: a data latch and a direction register. The block resolves, pin by pin, who drives the pad and with what value. It also brings the synchronized pad levels out to the peripherals.

When a peripheral is enabled, it does not simply take over its pins. Pins that the SPI reads are forced to inputs. Pins that the SPI drives reach the pad only if the matching direction bit is set. The slave-select pin is always an input in slave mode. In master mode it is either a mode-fault sense input or a plain output, depending on its direction bit.

A three-state machine watches the slave-select level while it is sensing for a mode fault. Its states are `MF_IDLE` (waiting), `MF_PULSE` (one-cycle fault pulse out) and `MF_HELD` (fault level still present, pulse already given). Its transitions are:
- IDLE→PULSE on an armed low level.
- PULSE→HELD while the level stays low.
- PULSE→IDLE and HELD→IDLE once the level is high or sensing is disarmed.

An optional wired-OR setting turns every driven pin into an open-drain output.

Top module: `spx_port`

## Requirements
- R1: After reset the direction and data registers hold 0, every pad is undriven (`pad_oe` = 0) and `mode_fault` is low.
- R2: With no peripheral owning a pin, direction bit 1 drives the data-latch bit on the pad and direction bit 0 leaves the pad undriven.
- R3: `reg_sel`=0 selects the data register and `reg_sel`=1 the direction register. Bits 7 and 6 of both read as 0, and writes to them are ignored.
- R4: A data-register read returns the latch bit for pins whose direction bit is 1. For the other pins it returns the pad level delayed by two clock edges through the synchronizer.
- R5: With `spi_en`=1, pins that the SPI reads are never driven, whatever their direction bits. In master mode (`spi_master`=1) that is pin 2. In slave mode it is pins 3, 4 and 5.
- R6: With `spi_en`=1, pins that the SPI drives carry the SPI value only while their direction bit is 1, and are undriven otherwise. In master mode these are pin 3 (MOSI) and pin 4 (SCK). In slave mode it is pin 2 (MISO).
- R7: In master mode, pin 5 with direction bit 1 drives its data-latch bit, and with direction bit 0 it is an undriven sense input.
- R8: In master mode with `spi_en`=1 and direction bit 5 = 0, a falling pad level on pin 5 gives exactly one `mode_fault` pulse of one cycle. The pulse is high in the third cycle after the low level reaches the pad. A new pulse needs the level to go high again first.
- R9: `mode_fault` stays low in slave mode, with the SPI disabled, or while direction bit 5 = 1.
- R10: With `ser_rx_en`=1, pin 0 is undriven regardless of its direction bit.
- R11: With `ser_tx_en`=1, pin 1 is driven with `ser_txd` regardless of its direction bit.
- R12: With `wired_or`=1, a driven pin whose value is 0 is driven low and a driven pin whose value is 1 is released. The pad is then never actively driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 = data register, 1 = direction register |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected register |
| pad_in | input | 6 | Pad levels |
| pad_oe | output | 6 | Pad output enables |
| pad_out | output | 6 | Pad output values |
| pin_level | output | 6 | Synchronized pad levels for the peripherals |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | 1 = master, 0 = slave |
| spi_sck_drv | input | 1 | SCK value from the SPI engine |
| spi_mosi_drv | input | 1 | MOSI value from the SPI engine |
| spi_miso_drv | input | 1 | MISO value from the SPI engine |
| ser_rx_en | input | 1 | Serial receiver enabled |
| ser_tx_en | input | 1 | Serial transmitter enabled |
| ser_txd | input | 1 | Serial transmit data |
| wired_or | input | 1 | Open-drain mode for all driven pins |
| mode_fault | output | 1 | One-cycle mode-fault pulse to the SPI |

## Verification
The bench targets pins where a peripheral enable and a direction bit disagree.

- An SPI output pin with its direction bit clear must float. A design that lets the enable override the direction bit would drive it.
- An SPI input pin with its direction bit set must also float. A design that trusts the direction bit would drive into the external master.

The slave-select pin is walked through slave mode, master-output mode and master-sense mode. A design that honoured the direction bit in slave mode, or raised a fault when not sensing, would fail there.

The fault pulse is timed to the exact cycle and checked across a level held low for many cycles. A level-sensitive design would repeat the pulse, and a missing re-arm would lose the second fault. Readback is sampled one edge before and one edge after the synchronizer settles.

// File: rtl/spx_pkg.sv
package spx_pkg;

    localparam int PIN_CNT = 6;

    // pin roles; the peripherals decode these positions
    localparam int P_RXD  = 0;
    localparam int P_TXD  = 1;
    localparam int P_MISO = 2;
    localparam int P_MOSI = 3;
    localparam int P_SCK  = 4;
    localparam int P_SS   = 5;

    typedef enum logic [1:0] {
        MODE_PLAIN,
        MODE_MASTER,
        MODE_SLAVE
    } spi_mode_t;

    typedef enum logic [1:0] {
        OWN_GPIO,      // direction/data registers decide
        OWN_FORCE_IN,  // peripheral reads it: never driven
        OWN_GATED,     // peripheral value, only if direction bit set
        OWN_FORCED     // peripheral value, always driven
    } pin_own_t;

    typedef enum logic [1:0] {
        MF_IDLE,
        MF_PULSE,
        MF_HELD
    } mf_state_t;

    function automatic pin_own_t pin_owner(int idx, spi_mode_t mode,
                                           logic rx_en, logic tx_en,
                                           logic ss_dir);
        pin_own_t r;
        if (idx == P_RXD) begin
            r = rx_en ? OWN_FORCE_IN : OWN_GPIO;
        end else if (idx == P_TXD) begin
            r = tx_en ? OWN_FORCED : OWN_GPIO;
        end else if (mode == MODE_PLAIN) begin
            r = OWN_GPIO;
        end else if (idx == P_SS) begin
            if (mode == MODE_SLAVE) r = OWN_FORCE_IN;
            else                    r = ss_dir ? OWN_GPIO : OWN_FORCE_IN;
        end else if (idx == P_MISO) begin
            r = (mode == MODE_SLAVE) ? OWN_GATED : OWN_FORCE_IN;
        end else begin
            r = (mode == MODE_MASTER) ? OWN_GATED : OWN_FORCE_IN;
        end
        return r;
    endfunction

endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/spx_regs.sv
module spx_regs
    import spx_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [PIN_CNT-1:0] pin_sync,
    output logic [PIN_CNT-1:0] dir_q,
    output logic [PIN_CNT-1:0] dat_q,
    output logic [REG_W-1:0]   reg_rdata
);
    localparam int PAD_W = REG_W - PIN_CNT;

    logic [PIN_CNT-1:0] data_view;
    logic               unused_hi;

    assign unused_hi = ^reg_wdata[REG_W-1:PIN_CNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel) dir_q <= reg_wdata[PIN_CNT-1:0];
            else         dat_q <= reg_wdata[PIN_CNT-1:0];
        end
    end

    always_comb begin
        data_view = (dir_q & dat_q) | (~dir_q & pin_sync);
        reg_rdata = reg_sel ? {{PAD_W{1'b0}}, dir_q} : {{PAD_W{1'b0}}, data_view};
    end

    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel |=> dir_q == $past(reg_wdata[PIN_CNT-1:0]));

    p_dat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(dat_q) && $stable(dir_q));
endmodule

// File: rtl/spx_pinmux.sv
module spx_pinmux
    import spx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  spi_mode_t          mode,
    input  logic               rx_en,
    input  logic               tx_en,
    input  logic               wired_or,
    input  logic [PIN_CNT-1:0] dir_q,
    input  logic [PIN_CNT-1:0] dat_q,
    input  logic [PIN_CNT-1:0] periph_val,
    output logic [PIN_CNT-1:0] pad_oe,
    output logic [PIN_CNT-1:0] pad_out
);
    logic [PIN_CNT-1:0] oe_raw;
    logic [PIN_CNT-1:0] val_raw;

    for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
        pin_own_t own;

        always_comb begin
            own = pin_owner(g, mode, rx_en, tx_en, dir_q[P_SS]);
            unique case (own)
                OWN_GPIO: begin
                    oe_raw[g]  = dir_q[g];
                    val_raw[g] = dat_q[g];
                end
                OWN_FORCE_IN: begin
                    oe_raw[g]  = 1'b0;
                    val_raw[g] = 1'b0;
                end
                OWN_GATED: begin
                    oe_raw[g]  = dir_q[g];
                    val_raw[g] = periph_val[g];
                end
                OWN_FORCED: begin
                    oe_raw[g]  = 1'b1;
                    val_raw[g] = periph_val[g];
                end
                default: begin
                    oe_raw[g]  = 1'b0;
                    val_raw[g] = 1'b0;
                end
            endcase
        end

        // open-drain: a 1 releases the pad
        assign pad_oe[g]  = oe_raw[g] & ~(wired_or & val_raw[g]);
        assign pad_out[g] = val_raw[g] & ~wired_or;
    end

    p_master_miso_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_MASTER |-> !pad_oe[P_MISO]);

    p_slave_inputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_SLAVE |-> pad_oe[P_SS:P_MOSI] == '0);

    p_sck_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_MASTER && !dir_q[P_SCK] |-> !pad_oe[P_SCK]);

    p_miso_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_SLAVE && !dir_q[P_MISO] |-> !pad_oe[P_MISO]);

    p_ss_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_MASTER && dir_q[P_SS] && !wired_or
        |-> pad_oe[P_SS] && pad_out[P_SS] == dat_q[P_SS]);

    p_rx_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> !pad_oe[P_RXD]);

    p_tx_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && !wired_or |-> pad_oe[P_TXD] && pad_out[P_TXD] == periph_val[P_TXD]);

    p_wor_no_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wired_or |-> (pad_oe & pad_out) == '0);
endmodule

// File: rtl/spx_fault_fsm.sv
module spx_fault_fsm
    import spx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  spi_mode_t mode,
    input  logic      ss_dir,
    input  logic      ss_level,
    output logic      mode_fault
);
    mf_state_t state_q, state_d;
    logic      armed;
    logic      fault_cond;

    assign armed      = (mode == MODE_MASTER) && !ss_dir;
    assign fault_cond = armed && !ss_level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MF_IDLE:  state_d = fault_cond ? MF_PULSE : MF_IDLE;
            MF_PULSE: state_d = fault_cond ? MF_HELD  : MF_IDLE;
            MF_HELD:  state_d = fault_cond ? MF_HELD  : MF_IDLE;
            default:  state_d = MF_IDLE;
        endcase
    end

    always_comb begin
        mode_fault = (state_q == MF_PULSE);
    end

    p_fault_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |=> !mode_fault);

    p_fault_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |-> $past(armed && !ss_level));
endmodule

// File: rtl/spx_port.sv
module spx_port
    import spx_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [PIN_CNT-1:0] pad_in,
    output logic [PIN_CNT-1:0] pad_oe,
    output logic [PIN_CNT-1:0] pad_out,
    output logic [PIN_CNT-1:0] pin_level,
    input  logic               spi_en,
    input  logic               spi_master,
    input  logic               spi_sck_drv,
    input  logic               spi_mosi_drv,
    input  logic               spi_miso_drv,
    input  logic               ser_rx_en,
    input  logic               ser_tx_en,
    input  logic               ser_txd,
    input  logic               wired_or,
    output logic               mode_fault
);
    logic [PIN_CNT-1:0] pin_sync;
    logic [PIN_CNT-1:0] dir_q;
    logic [PIN_CNT-1:0] dat_q;
    logic [PIN_CNT-1:0] periph_val;
    spi_mode_t          mode;

    always_comb begin
        if (!spi_en)         mode = MODE_PLAIN;
        else if (spi_master) mode = MODE_MASTER;
        else                 mode = MODE_SLAVE;

        periph_val         = '0;
        periph_val[P_TXD]  = ser_txd;
        periph_val[P_MISO] = spi_miso_drv;
        periph_val[P_MOSI] = spi_mosi_drv;
        periph_val[P_SCK]  = spi_sck_drv;
    end

    spx_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pin_sync)
    );

    spx_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .reg_rdata (reg_rdata)
    );

    spx_pinmux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .rx_en      (ser_rx_en),
        .tx_en      (ser_tx_en),
        .wired_or   (wired_or),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .periph_val (periph_val),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out)
    );

    spx_fault_fsm u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .ss_dir     (dir_q[P_SS]),
        .ss_level   (pin_sync[P_SS]),
        .mode_fault (mode_fault)
    );

    assign pin_level = pin_sync;

    p_fault_needs_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |-> $past(spi_en && spi_master));
endmodule

// File: tb/spx_port_tb_top.sv
module spx_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_oe, pad_out, pin_level;
    logic       spi_en = 0, spi_master = 0, spi_sck_drv = 0, spi_mosi_drv = 0, spi_miso_drv = 0;
    logic       ser_rx_en = 0, ser_tx_en = 0, ser_txd = 0, wired_or = 0;
    logic       mode_fault;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    spx_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pin_level(pin_level),
        .spi_en(spi_en), .spi_master(spi_master), .spi_sck_drv(spi_sck_drv),
        .spi_mosi_drv(spi_mosi_drv), .spi_miso_drv(spi_miso_drv),
        .ser_rx_en(ser_rx_en), .ser_tx_en(ser_tx_en), .ser_txd(ser_txd),
        .wired_or(wired_or), .mode_fault(mode_fault)
    );

    // ctl = {spi_en, spi_master, ser_rx_en, ser_tx_en, wired_or}
    // pv  = {sck, mosi, miso, txd}
    typedef struct packed {
        logic [4:0] ctl;
        logic [5:0] dir;
        logic [5:0] dat;
        logic [3:0] pv;
        logic [5:0] eoe;
        logic [5:0] eout;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [0:12] = '{
        '{5'b00000, 6'b111111, 6'b101010, 4'b0000, 6'b111111, 6'b101010, 4'd2},  // R2
        '{5'b00000, 6'b000000, 6'b111111, 4'b0000, 6'b000000, 6'b000000, 4'd2},  // R2
        '{5'b00000, 6'b010101, 6'b111000, 4'b0000, 6'b010101, 6'b010000, 4'd2},  // R2
        '{5'b11000, 6'b111111, 6'b000000, 4'b1010, 6'b111011, 6'b010000, 4'd6},  // R6, R5
        '{5'b11000, 6'b000100, 6'b000000, 4'b1100, 6'b000000, 6'b000000, 4'd5},  // R5
        '{5'b11000, 6'b111000, 6'b100000, 4'b0100, 6'b111000, 6'b101000, 4'd7},  // R7
        '{5'b10000, 6'b111111, 6'b111111, 4'b0010, 6'b000111, 6'b000111, 4'd5},  // R5
        '{5'b10000, 6'b111011, 6'b000011, 4'b0010, 6'b000011, 6'b000011, 4'd6},  // R6
        '{5'b00100, 6'b111111, 6'b000001, 4'b0000, 6'b111110, 6'b000000, 4'd10}, // R10
        '{5'b00010, 6'b000000, 6'b000000, 4'b0001, 6'b000010, 6'b000010, 4'd11}, // R11
        '{5'b00010, 6'b000000, 6'b000000, 4'b0000, 6'b000010, 6'b000000, 4'd11}, // R11
        '{5'b00001, 6'b111111, 6'b110011, 4'b0000, 6'b001100, 6'b000000, 4'd12}, // R12
        '{5'b00011, 6'b000001, 6'b000000, 4'b0001, 6'b000001, 6'b000000, 4'd12}  // R12
    };

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic step_fault(string req, logic exp);
        @(posedge clk);
        @(negedge clk);
        chk(req, "mode_fault", {31'b0, mode_fault}, {31'b0, exp});
    endtask

    task automatic count_pulses(int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (mode_fault) cnt++;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] rv;
        int         cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(1'b1, rv); chk("R1", "dir after reset", rv, 8'h00);
        rd(1'b0, rv); chk("R1", "data after reset", rv, 8'h00);
        chk("R1", "pad_oe after reset", pad_oe, 6'h00);
        chk("R1", "mode_fault after reset", mode_fault, 1'b0);

        // R3: upper bits read zero, writes there ignored
        wr(1'b1, 8'hFF); rd(1'b1, rv); chk("R3", "dir upper bits", rv, 8'h3F);
        wr(1'b0, 8'hC0); rd(1'b0, rv); chk("R3", "data upper bits", rv, 8'h00);

        // vector table: R2 R5 R6 R7 R10 R11 R12
        for (int i = 0; i <= 12; i++) begin
            {spi_en, spi_master, ser_rx_en, ser_tx_en, wired_or} = 5'b00000;
            wr(1'b1, {2'b00, VECS[i].dir});
            wr(1'b0, {2'b00, VECS[i].dat});
            {spi_en, spi_master, ser_rx_en, ser_tx_en, wired_or} = VECS[i].ctl;
            {spi_sck_drv, spi_mosi_drv, spi_miso_drv, ser_txd} = VECS[i].pv;
            #1;
            chk($sformatf("R%0d v%0d", VECS[i].req, i), "pad_oe", pad_oe, VECS[i].eoe);
            chk($sformatf("R%0d v%0d", VECS[i].req, i), "pad_out", pad_out & pad_oe, VECS[i].eout);
        end
        {spi_en, spi_master, ser_rx_en, ser_tx_en, wired_or} = 5'b00000;
        {spi_sck_drv, spi_mosi_drv, spi_miso_drv, ser_txd} = 4'b0000;

        // R4: readback mix and synchronizer latency
        wr(1'b1, 8'h00);
        pad_in = 6'b010110;
        @(posedge clk); @(negedge clk);
        rd(1'b0, rv); chk("R4", "data before sync settles", rv, 8'h00);
        @(posedge clk); @(negedge clk);
        rd(1'b0, rv); chk("R4", "data pins after sync", rv, 8'h16);
        chk("R4", "pin_level", pin_level, 6'b010110);
        wr(1'b1, 8'h0F); wr(1'b0, 8'h05);
        pad_in = 6'b110000;
        repeat (2) @(negedge clk);
        rd(1'b0, rv); chk("R4", "mixed readback", rv, 8'h35);

        // R8: mode-fault pulse timing, single pulse per low episode
        wr(1'b0, 8'h00);
        pad_in = 6'b100000;
        spi_en = 1'b1; spi_master = 1'b1;
        wr(1'b1, 8'h00);
        repeat (4) @(negedge clk);
        pad_in = 6'b000000;
        step_fault("R8", 1'b0);
        step_fault("R8", 1'b0);
        step_fault("R8", 1'b1);
        step_fault("R8", 1'b0);
        count_pulses(6, cnt); chk("R8", "pulses while held low", cnt, 0);
        pad_in = 6'b100000;
        count_pulses(4, cnt); chk("R8", "pulses on release", cnt, 0);
        pad_in = 6'b000000;
        count_pulses(8, cnt); chk("R8", "pulses after re-arm", cnt, 1);

        // R9: no fault in slave mode or with ss as output
        pad_in = 6'b100000;
        repeat (4) @(negedge clk);
        spi_master = 1'b0;
        pad_in = 6'b000000;
        count_pulses(6, cnt); chk("R9", "pulses in slave mode", cnt, 0);
        wr(1'b1, 8'h20);
        spi_master = 1'b1;
        count_pulses(6, cnt); chk("R9", "pulses with ss output", cnt, 0);
        spi_en = 1'b0;
        wr(1'b1, 8'h00);
        count_pulses(6, cnt); chk("R9", "pulses with spi off", cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule